// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block moves a small processor core from normal execution into exception handling. Exception requests come from inside the core (trap with a trap number, illegal or unimplemented opcode, privilege violation, trace, address error) and from outside it (bus or access error, reset request, and a 3-bit interrupt level). When a request wins arbitration, the sequencer takes a copy of the current status word. In the same cycle it writes back a new status word with supervisor mode on and tracing off, and it pulses a flush that aborts every younger instruction not yet at the execute stage.

The sequencer then resolves the vector number. Internal causes map to fixed vector numbers. An interrupt runs an acknowledge handshake, which presents the accepted level and waits for the outside to return either a vector or a spurious response. When the vector is known, a one-cycle done pulse carries the vector number and the saved status word to the core. Entry follows a restart model. An instruction at the execute stage that must not be interrupted is allowed to finish first, unless the pending cause is a reset or an access error on that instruction.

Top module: `exc_entry_seq`

## Requirements
- R1: After synchronous reset, flush, sr_we, done and iack_req are 0 and no request is pending.
- R2: An accepted request gives a one-cycle flush and sr_we pulse at the clock edge that samples it. saved_sr takes the sr_in value of that edge and holds it until the entry completes.
- R3: The written status word sr_out has bit 13 (supervisor) set and bit 15 (trace) cleared. All other bits outside the mask field are copied from sr_in.
- R4: The mask field, bits 10:8 of the status word, is loaded with the accepted level on an interrupt entry and with 7 on a reset entry. For every other cause it is left unchanged.
- R5: Simultaneous requests are served one at a time in this priority order: reset, bus error, address error, trap, illegal, privilege, trace, interrupt. Requests that lose stay pending and are served later in the same order.
- R6: An interrupt level is accepted only if it is greater than the current mask or equal to 7. Level 0 is never accepted.
- R7: On interrupt entry, iack_req rises with iack_level equal to the accepted level, and both hold until iack_vec_valid. vec_num is then taken from iack_vector.
- R8: If iack_spurious arrives without iack_vec_valid during the handshake, vec_num is 24.
- R9: Internal causes use these fixed vectors: reset 0, bus error 2, address error 3, illegal 4, privilege 8, trace 9, and trap 32 plus trap_num.
- R10: For internal causes, done pulses for one cycle on the edge after the flush. For interrupts, done pulses on the edge that samples the vector response. vec_num and saved_sr are valid while done is high.
- R11: While ex_noint is high, entry is held off for every cause except reset and bus error, which are taken at once. A held request is taken on the first edge where ex_noint is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sr_in | input | 16 | Current status word from the core |
| req_reset | input | 1 | Reset exception request pulse |
| req_buserr | input | 1 | Bus or access error request pulse |
| req_addrerr | input | 1 | Address error request pulse |
| req_trap | input | 1 | Trap request pulse |
| trap_num | input | 4 | Trap number sampled with req_trap |
| req_illegal | input | 1 | Illegal or unimplemented opcode pulse |
| req_priv | input | 1 | Privilege violation pulse |
| req_trace | input | 1 | Trace request pulse |
| irq_level | input | 3 | Interrupt request level, 0 means none |
| ex_noint | input | 1 | Execute-stage instruction must not be interrupted |
| iack_vec_valid | input | 1 | Acknowledge response carries a vector |
| iack_vector | input | 8 | Vector returned by the interrupting device |
| iack_spurious | input | 1 | Acknowledge ended with no device answering |
| iack_req | output | 1 | Interrupt acknowledge cycle in progress |
| iack_level | output | 3 | Level being acknowledged |
| flush | output | 1 | Abort younger pipeline instructions |
| sr_we | output | 1 | Write sr_out into the status register |
| sr_out | output | 16 | New status word for the handler |
| done | output | 1 | Vector and saved status are valid |
| vec_num | output | 8 | Resolved vector number |
| saved_sr | output | 16 | Status word copied before modification |

## Verification
A wrong pending bit shows up as a missing, extra or reordered done. The scoreboard catches this on the next vector it pops, usually within two to three cycles of the entry, because results are compared strictly in the expected order. A bad status-word update appears in sr_out in the very cycle of the flush, and the bench checks it there. A stuck state in the handshake shows as iack_req never falling or done never coming, which the drain check at the end reports. A bad hold-off decision shows as a flush appearing while ex_noint is high, and the bench samples flush in every held cycle.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int VW = 8;
  localparam int NSRC = 7;
  localparam int P_RST = 0;
  localparam int P_BUS = 1;
  localparam int P_ADR = 2;
  localparam int P_TRP = 3;
  localparam int P_ILL = 4;
  localparam int P_PRV = 5;
  localparam int P_TRC = 6;

  localparam logic [VW-1:0] V_RESET = 8'd0;
  localparam logic [VW-1:0] V_BUS   = 8'd2;
  localparam logic [VW-1:0] V_ADR   = 8'd3;
  localparam logic [VW-1:0] V_ILL   = 8'd4;
  localparam logic [VW-1:0] V_PRV   = 8'd8;
  localparam logic [VW-1:0] V_TRC   = 8'd9;
  localparam logic [VW-1:0] V_SPUR  = 8'd24;
  localparam logic [VW-1:0] V_TRAPB = 8'd32;

  typedef enum logic [3:0] {
    C_NONE, C_RESET, C_BUS, C_ADR, C_TRAP, C_ILL, C_PRV, C_TRC, C_IRQ
  } cause_e;

  typedef enum logic [1:0] {ST_IDLE, ST_VEC, ST_IACK} state_e;

  function automatic logic [VW-1:0] vec_of(cause_e c, logic [3:0] tn);
    case (c)
      C_RESET: vec_of = V_RESET;
      C_BUS:   vec_of = V_BUS;
      C_ADR:   vec_of = V_ADR;
      C_TRAP:  vec_of = V_TRAPB + {4'd0, tn};
      C_ILL:   vec_of = V_ILL;
      C_PRV:   vec_of = V_PRV;
      C_TRC:   vec_of = V_TRC;
      default: vec_of = V_SPUR;
    endcase
  endfunction

  function automatic logic [NSRC-1:0] pend_bit(cause_e c);
    pend_bit = '0;
    case (c)
      C_RESET: pend_bit[P_RST] = 1'b1;
      C_BUS:   pend_bit[P_BUS] = 1'b1;
      C_ADR:   pend_bit[P_ADR] = 1'b1;
      C_TRAP:  pend_bit[P_TRP] = 1'b1;
      C_ILL:   pend_bit[P_ILL] = 1'b1;
      C_PRV:   pend_bit[P_PRV] = 1'b1;
      C_TRC:   pend_bit[P_TRC] = 1'b1;
      default: pend_bit = '0;
    endcase
  endfunction
endpackage

// File: rtl/exc_prio_sel.sv
module exc_prio_sel
  import exc_pkg::*;
(
  input  logic [NSRC-1:0] pend,
  input  logic            irq_ok,
  input  logic            hold,
  output cause_e          cause
);
  cause_e pick;

  always_comb begin
    if      (pend[P_RST]) pick = C_RESET;
    else if (pend[P_BUS]) pick = C_BUS;
    else if (pend[P_ADR]) pick = C_ADR;
    else if (pend[P_TRP]) pick = C_TRAP;
    else if (pend[P_ILL]) pick = C_ILL;
    else if (pend[P_PRV]) pick = C_PRV;
    else if (pend[P_TRC]) pick = C_TRC;
    else if (irq_ok)      pick = C_IRQ;
    else                  pick = C_NONE;
  end

  // reset and access error bypass the non-interruptible hold
  always_comb begin
    if (hold && (pick != C_RESET) && (pick != C_BUS)) cause = C_NONE;
    else                                              cause = pick;
  end
endmodule

// File: rtl/exc_sr_update.sv
module exc_sr_update
  import exc_pkg::*;
#(
  parameter int SR_W    = 16,
  parameter int LVL_W   = 3,
  parameter int T_BIT   = 15,
  parameter int S_BIT   = 13,
  parameter int MASK_LO = 8
) (
  input  logic [SR_W-1:0]  sr_in,
  input  cause_e           cause,
  input  logic [LVL_W-1:0] lvl,
  output logic [SR_W-1:0]  sr_new
);
  always_comb begin
    sr_new        = sr_in;
    sr_new[T_BIT] = 1'b0;
    sr_new[S_BIT] = 1'b1;
    if (cause == C_RESET)    sr_new[MASK_LO +: LVL_W] = '1;
    else if (cause == C_IRQ) sr_new[MASK_LO +: LVL_W] = lvl;
  end
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int SR_W    = 16,
  parameter int LVL_W   = 3,
  parameter int TRAP_W  = 4,
  parameter int VEC_W   = 8,
  parameter int T_BIT   = 15,
  parameter int S_BIT   = 13,
  parameter int MASK_LO = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SR_W-1:0]   sr_in,
  input  logic              req_reset,
  input  logic              req_buserr,
  input  logic              req_addrerr,
  input  logic              req_trap,
  input  logic [TRAP_W-1:0] trap_num,
  input  logic              req_illegal,
  input  logic              req_priv,
  input  logic              req_trace,
  input  logic [LVL_W-1:0]  irq_level,
  input  logic              ex_noint,
  input  logic              iack_vec_valid,
  input  logic [VEC_W-1:0]  iack_vector,
  input  logic              iack_spurious,
  output logic              iack_req,
  output logic [LVL_W-1:0]  iack_level,
  output logic              flush,
  output logic              sr_we,
  output logic [SR_W-1:0]   sr_out,
  output logic              done,
  output logic [VEC_W-1:0]  vec_num,
  output logic [SR_W-1:0]   saved_sr
);
  localparam logic [LVL_W-1:0] LVL_MAX = '1;

  state_e            state;
  logic [NSRC-1:0]   pend_q, req_v, eff;
  logic [TRAP_W-1:0] trap_q, trap_eff;
  logic [LVL_W-1:0]  cur_mask;
  logic              irq_ok;
  cause_e            cause;
  logic [SR_W-1:0]   sr_new;

  always_comb begin
    req_v        = '0;
    req_v[P_RST] = req_reset;
    req_v[P_BUS] = req_buserr;
    req_v[P_ADR] = req_addrerr;
    req_v[P_TRP] = req_trap;
    req_v[P_ILL] = req_illegal;
    req_v[P_PRV] = req_priv;
    req_v[P_TRC] = req_trace;
  end

  assign eff      = pend_q | req_v;
  assign trap_eff = pend_q[P_TRP] ? trap_q : trap_num;
  assign cur_mask = sr_in[MASK_LO +: LVL_W];
  assign irq_ok   = (irq_level > cur_mask) || (irq_level == LVL_MAX);

  exc_prio_sel prio_i (
    .pend   (eff),
    .irq_ok (irq_ok),
    .hold   (ex_noint),
    .cause  (cause)
  );

  exc_sr_update #(
    .SR_W(SR_W), .LVL_W(LVL_W), .T_BIT(T_BIT), .S_BIT(S_BIT), .MASK_LO(MASK_LO)
  ) sru_i (
    .sr_in  (sr_in),
    .cause  (cause),
    .lvl    (irq_level),
    .sr_new (sr_new)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      pend_q     <= '0;
      trap_q     <= '0;
      iack_req   <= 1'b0;
      iack_level <= '0;
      flush      <= 1'b0;
      sr_we      <= 1'b0;
      sr_out     <= '0;
      done       <= 1'b0;
      vec_num    <= '0;
      saved_sr   <= '0;
    end else begin
      flush <= 1'b0;
      sr_we <= 1'b0;
      done  <= 1'b0;
      if (req_trap && !pend_q[P_TRP]) trap_q <= trap_num;
      pend_q <= eff;
      case (state)
        ST_IDLE: begin
          if (cause != C_NONE) begin
            flush    <= 1'b1;
            sr_we    <= 1'b1;
            sr_out   <= sr_new;
            saved_sr <= sr_in;
            pend_q   <= eff & ~pend_bit(cause);
            if (cause == C_IRQ) begin
              iack_req   <= 1'b1;
              iack_level <= irq_level;
              state      <= ST_IACK;
            end else begin
              vec_num <= VEC_W'(vec_of(cause, 4'(trap_eff)));
              state   <= ST_VEC;
            end
          end
        end
        ST_VEC: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        ST_IACK: begin
          if (iack_vec_valid) begin
            vec_num  <= iack_vector;
            done     <= 1'b1;
            iack_req <= 1'b0;
            state    <= ST_IDLE;
          end else if (iack_spurious) begin
            vec_num  <= VEC_W'(V_SPUR);
            done     <= 1'b1;
            iack_req <= 1'b0;
            state    <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  flush_done_excl_chk: assert property (@(posedge clk) disable iff (rst)
    flush |-> !done);

  // R2
  saved_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE && !flush) |-> $stable(saved_sr));

  // R3
  sr_mode_chk: assert property (@(posedge clk) disable iff (rst)
    sr_we |-> (sr_out[S_BIT] && !sr_out[T_BIT]));

  // R7
  iack_level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (iack_req && $past(iack_req)) |-> $stable(iack_level));

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  noint_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flush) |-> (!$past(ex_noint) ||
      $past(req_reset || req_buserr || pend_q[P_RST] || pend_q[P_BUS])));
endmodule

// File: tb/exc_entry_seq_tb_top.sv
`timescale 1ns/1ps
module exc_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sr_in = 16'h8304;
  logic [6:0]  reqv = '0;
  logic [3:0]  trap_num = '0;
  logic [2:0]  irq_level = '0;
  logic        ex_noint = 1'b0;
  logic        iack_vec_valid = 1'b0;
  logic [7:0]  iack_vector = '0;
  logic        iack_spurious = 1'b0;
  logic        iack_req, flush, sr_we, done;
  logic [2:0]  iack_level;
  logic [15:0] sr_out, saved_sr;
  logic [7:0]  vec_num;

  int checks = 0;
  int errors = 0;
  logic [23:0] exp_q[$];

  always #2 clk = ~clk;

  exc_entry_seq dut_i (
    .clk(clk), .rst(rst), .sr_in(sr_in),
    .req_reset(reqv[0]), .req_buserr(reqv[1]), .req_addrerr(reqv[2]),
    .req_trap(reqv[3]), .trap_num(trap_num), .req_illegal(reqv[4]),
    .req_priv(reqv[5]), .req_trace(reqv[6]), .irq_level(irq_level),
    .ex_noint(ex_noint), .iack_vec_valid(iack_vec_valid),
    .iack_vector(iack_vector), .iack_spurious(iack_spurious),
    .iack_req(iack_req), .iack_level(iack_level), .flush(flush),
    .sr_we(sr_we), .sr_out(sr_out), .done(done), .vec_num(vec_num),
    .saved_sr(saved_sr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // expected status word after entry (R3, R4)
  function automatic logic [15:0] new_sr(input logic [15:0] s, input int mode, input logic [2:0] lv);
    logic [15:0] r;
    r = s; r[15] = 1'b0; r[13] = 1'b1;
    if (mode == 1) r[10:8] = 3'd7;
    else if (mode == 2) r[10:8] = lv;
    return r;
  endfunction

  // monitor: pops expected results as done appears (R10)
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) chk(1'b0, "R10 unexpected done", vec_num, 0);
      else begin
        logic [23:0] e;
        e = exp_q.pop_front();
        chk(vec_num == e[23:16], "R9 vector", vec_num, e[23:16]);
        chk(saved_sr == e[15:0], "R2 saved_sr", saved_sr, e[15:0]);
      end
    end
  end

  // driver for an internal cause
  task automatic fire(input int bitn, input logic [3:0] tn, input logic [7:0] ev, input int mode);
    @(negedge clk);
    reqv = '0; reqv[bitn] = 1'b1; trap_num = tn;
    exp_q.push_back({ev, sr_in});
    @(negedge clk);
    reqv = '0;
    chk(flush && sr_we, "R2 flush", flush, 1);
    chk(sr_out == new_sr(sr_in, mode, 3'd0), "R3 sr_out", sr_out, new_sr(sr_in, mode, 3'd0));
    repeat (2) @(negedge clk);
  endtask

  task automatic irq(input logic [2:0] lv, input bit spur, input logic [7:0] dv);
    @(negedge clk);
    irq_level = lv;
    exp_q.push_back({spur ? 8'd24 : dv, sr_in});
    @(negedge clk);
    chk(iack_req && iack_level == lv, "R7 iack level", iack_level, lv);
    chk(sr_out == new_sr(sr_in, 2, lv), "R4 irq mask", sr_out, new_sr(sr_in, 2, lv));
    irq_level = '0;
    repeat (2) @(negedge clk);
    chk(iack_req, "R7 iack held", iack_req, 1);
    if (spur) iack_spurious = 1'b1; else begin iack_vec_valid = 1'b1; iack_vector = dv; end
    @(negedge clk);
    iack_spurious = 1'b0; iack_vec_valid = 1'b0;
    chk(!iack_req, "R7 iack release", iack_req, 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!flush && !sr_we && !done && !iack_req, "R1 reset state", {flush, sr_we, done, iack_req}, 0);

    fire(4, 4'd0, 8'd4, 0);            // illegal
    fire(3, 4'd5, 8'd37, 0);           // trap 5 -> 32+5 (R9)
    fire(5, 4'd0, 8'd8, 0);            // privilege
    fire(6, 4'd0, 8'd9, 0);            // trace
    fire(2, 4'd0, 8'd3, 0);            // address error
    fire(1, 4'd0, 8'd2, 0);            // bus error
    fire(0, 4'd0, 8'd0, 1);            // reset, mask -> 7 (R4)

    // R5: three at once, served address, illegal, trace
    @(negedge clk);
    reqv = 7'b1010100;
    exp_q.push_back({8'd3, sr_in});
    exp_q.push_back({8'd4, sr_in});
    exp_q.push_back({8'd9, sr_in});
    @(negedge clk);
    reqv = '0;
    chk(flush, "R5 first entry", flush, 1);
    repeat (8) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all served", exp_q.size(), 0);

    // R6: level 2 and 3 with mask 3 are ignored
    for (int lv = 2; lv <= 3; lv++) begin
      @(negedge clk);
      irq_level = 3'(lv);
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(!flush && !iack_req, "R6 irq ignored", {flush, iack_req}, 0);
      end
      irq_level = '0;
    end

    irq(3'd5, 1'b0, 8'h40);            // R7 vector from bus
    irq(3'd6, 1'b1, 8'h00);            // R8 spurious
    sr_in = 16'h0700;
    irq(3'd7, 1'b0, 8'h55);            // R6 level 7 at mask 7
    sr_in = 16'h8304;

    // R11: non-interruptible hold
    @(negedge clk);
    ex_noint = 1'b1; reqv[4] = 1'b1;
    exp_q.push_back({8'd4, sr_in});
    @(negedge clk);
    reqv = '0;
    chk(!flush, "R11 held", flush, 0);
    repeat (2) begin
      @(negedge clk);
      chk(!flush, "R11 still held", flush, 0);
    end
    ex_noint = 1'b0;
    @(negedge clk);
    chk(flush, "R11 released", flush, 1);
    repeat (3) @(negedge clk);
    ex_noint = 1'b1;
    fire(1, 4'd0, 8'd2, 0);            // R11 bus error bypasses hold
    ex_noint = 1'b0;

    repeat (6) @(negedge clk);
    chk(exp_q.size() == 0, "R10 drain", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule